// File: doc/BRIEF.md
# Byte-Level I2C Bus Master

This block drives an I2C bus one byte at a time and hands control back to software after every byte. Software loads an 8-bit data register, picks a direction and issues a START through a mode register. The block then sends the address byte and returns the bus to software by setting a pending flag. While that flag is set, SCL is held low. Software reads or reloads the data register, optionally arms a STOP or a repeated START, and writes a zero to the pending flag to let the next step run. The ACK of each byte is captured and can be read back. In receive mode, the block drives ACK or NACK according to an enable bit.

The SCL rate comes from a two-value prescaler (16 or 512) followed by a 4-bit divisor. Each bit is split into four equal quarter phases: SDA changes in the second quarter, SCL is high in the last two, and SDA is sampled in the fourth. Both bus lines are open drain. The block only ever pulls a line low, and SDA is read back through a short synchronizer.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the control register (address 0) and the mode register (address 1) read as 0x00, neither bus line is pulled low, and `irq` is low.
- R2: One SCL period lasts P*(D+1) clock cycles. P is 16 when control bit 6 is 0 and 512 when it is 1. D is control bits 3:0.
- R3: Writing the mode register with bit 5 = 1 and bit 4 = 1 while idle produces a START (SDA falls while SCL is high). The block then shifts out the data register (address 2), most significant bit first. Mode read bit 5 (busy) reads 1 from that write until the STOP completes.
- R4: Control bit 4 (pending) sets when SCL falls after the ninth SCL pulse of a byte, and SCL stays low for as long as it is set. `irq` equals pending AND control bit 5.
- R5: Writing control bit 4 = 0 clears pending and resumes the bus. Writing 1 to that bit never sets it.
- R6: In transmit mode (mode bits 7:6 = 11), each byte after the address comes from the data register. Mode read bit 0 holds the SDA level sampled at the ninth pulse: 0 for ACK, 1 for NACK.
- R7: In receive mode (mode bits 7:6 = 10), each byte after the address is sampled into the data register. During the ninth pulse the master pulls SDA low if control bit 7 is 1 and releases it (NACK) if that bit is 0.
- R8: Writing the mode register with bit 5 = 0 and bit 4 = 1 while pending makes the next resume produce a STOP (SDA rises while SCL is high). Busy then clears, and both lines are released whenever busy is 0.
- R9: Writing the mode register with bit 5 = 1 and bit 4 = 1 while pending makes the next resume produce a repeated START, followed by a transmitted address byte taken from the data register.
- R10: A mode register write with bit 4 = 0 issues no bus command: no START, busy stays 0 and the lines stay released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 mode/status, 2 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of `reg_addr`, registered (one cycle late) |
| irq | output | 1 | Pending flag gated by its enable |
| sda_in | input | 1 | Level of the SDA line |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The assertions assume that software writes the data and mode registers only while the block is idle or pending, never in the middle of a byte. They also assume that nothing else on the bus stretches SCL or drives SDA while SCL is high, except to form a START or STOP. The bench's bus target model follows those rules: it changes SDA only on SCL falling edges. The bench's register sequences issue commands only after polling the pending flag or busy bit. Random transfers vary the divisor, pointer, length and data inside those limits.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_START, ST_BIT, ST_HOLD, ST_STOP} eng_st_t;
  typedef enum logic [1:0] {CMD_NONE, CMD_STOP, CMD_RESTART} cmd_t;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_MODE = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  localparam int DIV_W   = 4;
  localparam int C_ACK   = 7;
  localparam int C_PRE   = 6;
  localparam int C_IEN   = 5;
  localparam int C_PEND  = 4;
  localparam int M_STST  = 5;
  localparam int M_TRX   = 4;
endpackage

// File: rtl/i2cm_clkdiv.sv
module i2cm_clkdiv #(
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 512,
  parameter int DIV_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             pre_hi,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  localparam int Q_LO = PRE_LO / 4;
  localparam int Q_HI = PRE_HI / 4;
  localparam int PW   = $clog2(Q_HI);

  logic [PW-1:0]    pcnt;
  logic [DIV_W-1:0] dcnt;
  logic [PW-1:0]    plim;

  assign plim = pre_hi ? PW'(Q_HI - 1) : PW'(Q_LO - 1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pcnt <= '0;
      dcnt <= '0;
      tick <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (pcnt == plim) begin
        pcnt <= '0;
        if (dcnt == div) begin
          dcnt <= '0;
          tick <= 1'b1;
        end else begin
          dcnt <= dcnt + 1'b1;
        end
      end else begin
        pcnt <= pcnt + 1'b1;
      end
    end
  end

  // R2: quarter-phase ticks are never back to back
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    (run && tick) |=> !tick);
endmodule

// File: rtl/i2cm_regs.sv
module i2cm_regs
  import i2cm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [DW-1:0]    wdata,
  input  logic             byte_done,
  input  logic [DW-1:0]    dreg,
  input  logic             busy,
  input  logic             last_ack,
  output logic [DW-1:0]    rdata,
  output logic             ack_en,
  output logic             pre_hi,
  output logic [DIV_W-1:0] div,
  output logic             pend,
  output logic             irq,
  output logic             mode_rx,
  output logic             start_req,
  output logic             stop_req,
  output logic             resume,
  output logic             data_we
);
  logic       ien_q;
  logic [1:0] mode_q;
  logic       trx_q;
  logic       ctrl_wr, mode_wr;

  assign ctrl_wr   = wr_en && (addr == A_CTRL);
  assign mode_wr   = wr_en && (addr == A_MODE);
  assign data_we   = wr_en && (addr == A_DATA);
  assign start_req = mode_wr && wdata[M_TRX] && wdata[M_STST];
  assign stop_req  = mode_wr && wdata[M_TRX] && !wdata[M_STST];
  assign resume    = ctrl_wr && !wdata[C_PEND] && pend;
  assign mode_rx   = (mode_q == 2'b10);
  assign irq       = pend && ien_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_en <= 1'b0;
      pre_hi <= 1'b0;
      ien_q  <= 1'b0;
      pend   <= 1'b0;
      div    <= '0;
      mode_q <= 2'b00;
      trx_q  <= 1'b0;
      rdata  <= '0;
    end else begin
      if (ctrl_wr) begin
        ack_en <= wdata[C_ACK];
        pre_hi <= wdata[C_PRE];
        ien_q  <= wdata[C_IEN];
        div    <= wdata[DIV_W-1:0];
        if (!wdata[C_PEND]) pend <= 1'b0;
      end
      if (byte_done) pend <= 1'b1;
      if (mode_wr) begin
        mode_q <= wdata[7:6];
        trx_q  <= wdata[M_TRX];
      end
      case (addr)
        A_CTRL:  rdata <= {ack_en, pre_hi, ien_q, pend, div};
        A_MODE:  rdata <= {mode_q, busy, trx_q, 3'b000, last_ack};
        A_DATA:  rdata <= dreg;
        default: rdata <= '0;
      endcase
    end
  end

  // R5: only a zero written to the pending bit can clear it
  assert_pend_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (pend && !(ctrl_wr && !wdata[C_PEND])) |=> pend);
  // R4: a completed byte always leaves the flag set
  assert_pend_set_R4: assert property (@(posedge clk) disable iff (rst)
    byte_done |=> pend);
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          start_req,
  input  logic          stop_req,
  input  logic          resume,
  input  logic          mode_rx,
  input  logic          ack_en,
  input  logic          data_we,
  input  logic [DW-1:0] data_in,
  input  logic          sda_in,
  output logic          run,
  output logic          scl_low,
  output logic          sda_low,
  output logic [DW-1:0] dreg,
  output logic          busy,
  output logic          last_ack,
  output logic          byte_done
);
  localparam int BW = $clog2(DW + 2);
  localparam logic [BW-1:0] ACK_SLOT = BW'(DW);
  localparam logic [BW-1:0] END_SLOT = BW'(DW + 1);

  eng_st_t       st;
  cmd_t          cmd;
  logic [1:0]    q;
  logic [BW-1:0] bitn;
  logic          rx_byte;
  logic          scl_q, sda_q;

  assign run     = (st == ST_START) || (st == ST_BIT) || (st == ST_STOP);
  assign scl_low = !scl_q;
  assign sda_low = !sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cmd       <= CMD_NONE;
      q         <= '0;
      bitn      <= '0;
      rx_byte   <= 1'b0;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      dreg      <= '0;
      busy      <= 1'b0;
      last_ack  <= 1'b0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (data_we) dreg <= data_in;
          if (start_req) begin
            st   <= ST_START;
            q    <= '0;
            busy <= 1'b1;
          end
        end
        ST_HOLD: begin
          if (data_we) dreg <= data_in;
          if (start_req)     cmd <= CMD_RESTART;
          else if (stop_req) cmd <= CMD_STOP;
          if (resume) begin
            cmd <= CMD_NONE;
            q   <= '0;
            case (cmd)
              CMD_STOP:    st <= ST_STOP;
              CMD_RESTART: st <= ST_START;
              default: begin
                st      <= ST_BIT;
                bitn    <= '0;
                rx_byte <= mode_rx;
              end
            endcase
          end
        end
        ST_START: if (tick) begin
          q <= q + 1'b1;
          case (q)
            2'd0: sda_q <= 1'b1;
            2'd1: scl_q <= 1'b1;
            2'd2: sda_q <= 1'b0;
            default: begin
              st      <= ST_BIT;
              bitn    <= '0;
              rx_byte <= 1'b0;
            end
          endcase
        end
        ST_BIT: if (tick) begin
          q <= q + 1'b1;
          case (q)
            2'd0: begin
              scl_q <= 1'b0;
              if (bitn == END_SLOT) begin
                st        <= ST_HOLD;
                byte_done <= 1'b1;
              end
            end
            2'd1: begin
              if (bitn == ACK_SLOT) sda_q <= rx_byte ? !ack_en : 1'b1;
              else                  sda_q <= rx_byte ? 1'b1 : dreg[DW-1];
            end
            2'd2: scl_q <= 1'b1;
            default: begin
              if (bitn == ACK_SLOT) last_ack <= sda_in;
              else                  dreg <= {dreg[DW-2:0], sda_in};
              bitn <= bitn + 1'b1;
            end
          endcase
        end
        ST_STOP: if (tick) begin
          q <= q + 1'b1;
          case (q)
            2'd0: sda_q <= 1'b0;
            2'd1: scl_q <= 1'b1;
            2'd2: sda_q <= 1'b1;
            default: begin
              st   <= ST_IDLE;
              busy <= 1'b0;
            end
          endcase
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3 and R8: SDA moves under a high SCL only to form START or STOP
  assert_sda_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (scl_q && $past(scl_q) && !$stable(sda_q)) |->
      ($past(st) == ST_START || $past(st) == ST_STOP));
  // R4: a byte can complete only inside a transfer
  assert_done_in_transfer_R4: assert property (@(posedge clk) disable iff (rst)
    byte_done |-> busy);
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int PRE_LO      = 16,
  parameter int PRE_HI      = 512,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reg_wr,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       sda_in,
  output logic       scl_drive_low,
  output logic       sda_drive_low
);
  localparam int DW = 8;

  logic [SYNC_STAGES-1:0] sda_sync;
  logic             sda_s;
  logic             tick, run;
  logic             ack_en, pre_hi, pend, mode_rx;
  logic [DIV_W-1:0] div;
  logic             start_req, stop_req, resume, data_we;
  logic [DW-1:0]    dreg;
  logic             busy, last_ack, byte_done;

  generate
    if (SYNC_STAGES > 1) begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) sda_sync <= '1;
        else     sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
      end
    end else begin : g_nosync
      always_ff @(posedge clk) begin
        if (rst) sda_sync <= '1;
        else     sda_sync <= sda_in;
      end
    end
  endgenerate
  assign sda_s = sda_sync[SYNC_STAGES-1];

  i2cm_clkdiv #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI), .DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .run(run), .pre_hi(pre_hi), .div(div), .tick(tick)
  );

  i2cm_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .byte_done(byte_done), .dreg(dreg), .busy(busy), .last_ack(last_ack),
    .rdata(reg_rdata), .ack_en(ack_en), .pre_hi(pre_hi), .div(div),
    .pend(pend), .irq(irq), .mode_rx(mode_rx), .start_req(start_req),
    .stop_req(stop_req), .resume(resume), .data_we(data_we)
  );

  i2cm_engine #(.DW(DW)) u_eng (
    .clk(clk), .rst(rst), .tick(tick), .start_req(start_req),
    .stop_req(stop_req), .resume(resume), .mode_rx(mode_rx), .ack_en(ack_en),
    .data_we(data_we), .data_in(reg_wdata), .sda_in(sda_s), .run(run),
    .scl_low(scl_drive_low), .sda_low(sda_drive_low), .dreg(dreg),
    .busy(busy), .last_ack(last_ack), .byte_done(byte_done)
  );

  // R4: the clock line stays low for the whole time the flag is pending
  assert_scl_held_R4: assert property (@(posedge clk) disable iff (rst)
    pend |-> scl_drive_low);
  // R8: when no transfer is open both lines are free
  assert_idle_released_R8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!scl_drive_low && !sda_drive_low));
endmodule

// File: tb/i2c_byte_master_tb_top.sv
module i2c_byte_master_tb_top;
  localparam logic [1:0] A_CTRL = 2'd0, A_MODE = 2'd1, A_DATA = 2'd2;
  localparam logic [6:0] SLV = 7'h2C;

  logic       clk = 1'b0, rst = 1'b1, reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  wire  [7:0] reg_rdata;
  wire        irq, scl_drive_low, sda_drive_low;
  logic       s_drv = 1'b0;
  wire        scl_line = !scl_drive_low;
  wire        sda_line = !(sda_drive_low || s_drv);

  i2c_byte_master dut_i (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .sda_in(sda_line), .scl_drive_low(scl_drive_low),
    .sda_drive_low(sda_drive_low)
  );

  always #2 clk = ~clk;

  int errors = 0, checks = 0;
  int cyc = 0, last_rise = 0, per = 0, rises = 0;
  int n_start = 0, n_stop = 0;
  logic [7:0] ctrl;
  logic [7:0] expmem [16];
  logic [7:0] smem [16];
  logic [7:0] wbuf [4];

  always @(posedge clk) cyc++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- bus target model ----------------
  int         s_bit = 0;
  bit         s_act = 0, s_addrph = 0, s_rd = 0, s_first = 0, s_match = 0, s_send = 0;
  logic       s_mack = 1'b1;
  logic [7:0] s_sh = 8'd0, s_tx = 8'd0;
  logic [3:0] ptr = 4'd0;

  always @(negedge sda_line) if (scl_line === 1'b1) begin
    n_start++; s_act = 1; s_bit = 0; s_addrph = 1; s_send = 0; s_drv = 1'b0;
  end
  always @(posedge sda_line) if (scl_line === 1'b1) begin
    n_stop++; s_act = 0; s_send = 0; s_drv = 1'b0;
  end
  always @(posedge scl_line) begin
    rises++;
    per = cyc - last_rise;
    last_rise = cyc;
    if (s_act) begin
      if (s_bit < 8) s_sh = {s_sh[6:0], sda_line};
      else           s_mack = sda_line;
      s_bit++;
    end
  end
  always @(negedge scl_line) if (s_act) begin
    if (s_bit == 8) begin
      if (s_addrph) begin
        s_match = (s_sh[7:1] == SLV); s_rd = s_sh[0]; s_first = 1; s_drv = s_match;
      end else if (!s_rd) begin
        if (s_first) ptr = s_sh[3:0];
        else begin smem[ptr] = s_sh; ptr++; end
        s_first = 0; s_drv = 1'b1;
      end else s_drv = 1'b0;
    end else if (s_bit == 9) begin
      s_bit = 0; s_drv = 1'b0;
      if (!s_match) s_act = 0;
      else if (s_rd && (s_addrph || !s_mack)) begin
        s_tx = smem[ptr]; ptr++; s_send = 1; s_drv = !s_tx[7];
      end else s_send = 0;
      s_addrph = 0;
    end else if (s_bit >= 1 && s_bit <= 7 && s_send) begin
      s_drv = !s_tx[7 - s_bit];
    end
  end

  // ---------------- register access ----------------
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (irq !== 1'b1 && n < 60000) begin @(negedge clk); n++; end
    if (n >= 60000) chk(req, 0, 1);
  endtask

  task automatic wait_idle(input string req);
    logic [7:0] m;
    int n = 0;
    rd(A_MODE, m);
    while (m[5] && n < 20000) begin rd(A_MODE, m); n++; end
    chk(req, m[5], 1'b0);
  endtask

  task automatic go();
    rises = 0;
    wr(A_CTRL, ctrl & 8'hEF);
  endtask

  function automatic int exp_period(input logic [7:0] c);
    return (c[6] ? 512 : 16) * (int'(c[3:0]) + 1);
  endfunction

  // ---------------- transactions ----------------
  task automatic xfer_write(input logic [3:0] p, input int n);
    logic [7:0] m;
    wr(A_DATA, {SLV, 1'b0}); rises = 0; wr(A_MODE, 8'hF0);
    wait_irq("R3");
    rd(A_MODE, m); chk("R6 address ack", m[0], 1'b0);
    wr(A_DATA, {4'h0, p}); go(); wait_irq("R6");
    for (int i = 0; i < n; i++) begin
      wr(A_DATA, wbuf[i]); go(); wait_irq("R6");
      rd(A_MODE, m); chk("R6 data ack", m[0], 1'b0);
      expmem[p + 4'(i)] = wbuf[i];
    end
    wr(A_MODE, 8'hD0); go(); wait_idle("R8 busy clears after stop");
  endtask

  task automatic xfer_read(input logic [3:0] p, input int n);
    logic [7:0] m, d;
    int s0;
    s0 = n_start;
    wr(A_DATA, {SLV, 1'b0}); wr(A_MODE, 8'hF0); wait_irq("R9");
    wr(A_DATA, {4'h0, p}); go(); wait_irq("R9");
    wr(A_DATA, {SLV, 1'b1}); wr(A_MODE, 8'hB0); go(); wait_irq("R9");
    chk("R9 repeated start seen", n_start - s0, 2);
    rd(A_MODE, m); chk("R9 read address ack", m[0], 1'b0);
    for (int i = 0; i < n; i++) begin
      if (i == n - 1) begin ctrl = ctrl & 8'h7F; wr(A_CTRL, ctrl | 8'h10); end
      go(); wait_irq("R7");
      rd(A_DATA, d); chk("R7 received byte", d, expmem[p + 4'(i)]);
      rd(A_MODE, m); chk("R7 ninth bit", m[0], (i == n - 1) ? 1'b1 : 1'b0);
    end
    ctrl = ctrl | 8'h80;
    wr(A_CTRL, ctrl | 8'h10);
    wr(A_MODE, 8'h90); go(); wait_idle("R8 stop after read");
  endtask

  // ---------------- main sequence ----------------
  bit done = 0;

  initial begin
    logic [7:0] r;
    int sc, hold_ok, s0, p0;
    for (int i = 0; i < 16; i++) begin smem[i] = 8'h00; expmem[i] = 8'h00; end
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(A_CTRL, r); chk("R1 control reset", r, 8'h00);
    rd(A_MODE, r); chk("R1 mode reset", r, 8'h00);
    chk("R1 lines released", {scl_drive_low, sda_drive_low, irq}, 3'b000);

    // R5 writing 1 to pending has no effect
    ctrl = 8'hA1;
    wr(A_CTRL, ctrl | 8'h10);
    rd(A_CTRL, r); chk("R5 pending not settable", r, 8'hA1);
    chk("R5 irq stays low", irq, 1'b0);

    // R10 command without tx/rx enable is ignored
    s0 = n_start;
    wr(A_DATA, 8'h55); wr(A_MODE, 8'hE0);
    repeat (200) @(negedge clk);
    rd(A_MODE, r); chk("R10 busy stays 0", r[5], 1'b0);
    chk("R10 no START", n_start - s0, 0);
    chk("R10 lines released", {scl_drive_low, sda_drive_low}, 2'b00);

    // R3 R4 R6 R8 directed write of one byte
    ctrl = 8'hA0;
    wr(A_CTRL, ctrl);
    s0 = n_start;
    wr(A_DATA, {SLV, 1'b0}); rises = 0; wr(A_MODE, 8'hF0);
    wait_irq("R3");
    chk("R3 START generated", n_start - s0, 1);
    chk("R3 address shifted MSB first", s_sh, {SLV, 1'b0});
    chk("R4 ninth pulse", rises, 9);
    rd(A_MODE, r); chk("R3 busy while open", r[5], 1'b1);
    chk("R6 ack captured", r[0], 1'b0);
    hold_ok = 1;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (!scl_drive_low) hold_ok = 0; end
    chk("R4 SCL held low while pending", hold_ok, 1);
    wr(A_DATA, 8'h03); go(); wait_irq("R5");
    chk("R5 resume runs one byte", rises, 9);
    wr(A_DATA, 8'hC6); go(); wait_irq("R6");
    p0 = n_stop;
    wr(A_MODE, 8'hD0); go(); wait_idle("R8");
    chk("R8 STOP generated", n_stop - p0, 1);
    chk("R6 byte delivered", smem[3], 8'hC6);
    expmem[3] = 8'hC6;

    // R4 R6 NACK with interrupt disabled: poll the flag
    ctrl = 8'h80;
    wr(A_CTRL, ctrl);
    wr(A_DATA, 8'h22); wr(A_MODE, 8'hF0);
    rd(A_CTRL, r); sc = 0;
    while (!r[4] && sc < 5000) begin rd(A_CTRL, r); sc++; end
    chk("R4 pending without enable", r[4], 1'b1);
    chk("R4 irq gated off", irq, 1'b0);
    rd(A_MODE, r); chk("R6 NACK reads 1", r[0], 1'b1);
    wr(A_MODE, 8'hD0); go(); wait_idle("R8");

    // R2 clock rate: small prescaler with two divisors and large prescaler
    for (int k = 0; k < 3; k++) begin
      ctrl = (k == 0) ? 8'hA0 : (k == 1) ? 8'hA3 : 8'hE0;
      wr(A_CTRL, ctrl);
      wr(A_DATA, {SLV, 1'b0}); wr(A_MODE, 8'hF0); wait_irq("R2");
      chk("R2 SCL period", per, exp_period(ctrl));
      wr(A_MODE, 8'hD0); go(); wait_idle("R2");
    end

    // R7 R9 directed read of the byte written earlier
    ctrl = 8'hA0; wr(A_CTRL, ctrl);
    xfer_read(4'd3, 1);

    // randomized write then read back
    for (int t = 0; t < 5; t++) begin
      logic [3:0] p;
      int n;
      ctrl = 8'hA0 | 8'($urandom % 3);
      wr(A_CTRL, ctrl);
      p = 4'($urandom % 12);
      n = 1 + int'($urandom % 3);
      for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
      xfer_write(p, n);
      xfer_read(p, n);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule